// File: doc/BRIEF.md
# Receive Queue with Drain Request Flag

This block holds words received by a serial peripheral until the host or a DMA engine takes them. The shift engine offers a word with a one-cycle push strobe. A reader removes the oldest word by reading a pop register. The pop register read is modelled as a one-cycle strobe, and the head word is presented on `pop_data` in that same cycle. An occupancy counter tracks how many words are waiting.

A drain request flag tells the host or DMA that service is needed. The flag goes high whenever words are waiting. Once set, it stays high after the queue runs dry until one of two things clears it: a software write-one-to-clear, or a DMA completion indication that arrives while the queue ends the cycle empty. A pop on an empty queue is ignored. A push into a full queue is dropped and raises a sticky overflow flag, which is also write-one-to-clear.

Top module: `rxq_drain_fifo`

## Requirements
- R1: While reset is asserted and after it is released, `fill_count` is 0 and both `drain_flag` and `overflow_flag` are 0.
- R2: Words leave in the order they were accepted. `pop_data` shows the oldest word combinationally. A `pop_rd` strobe on a non-empty queue removes that word, and `fill_count` drops by one at the next clock edge.
- R3: A `pop_rd` strobe on an empty queue leaves `fill_count` and the stored words unchanged. The value on `pop_data` during such a strobe is unspecified.
- R4: Whenever `fill_count` is non-zero, `drain_flag` is 1.
- R5: When `dma_pop_done` is high in a cycle that leaves the queue empty, `drain_flag` is 0 after the next clock edge. When that cycle leaves the queue non-empty, the flag stays 1.
- R6: When `clr_drain` is high in a cycle that leaves the queue empty, `drain_flag` is 0 after the next clock edge.
- R7: When `clr_drain` is high in a cycle that leaves the queue non-empty, `drain_flag` is 1 after the next clock edge, because setting wins over clearing.
- R8: A push while `fill_count` equals the depth (4 by default) is dropped and leaves the stored words and the count unchanged. It also sets `overflow_flag`, which then stays 1 until it is cleared.
- R9: `clr_ovf` clears `overflow_flag` at the next edge, except in a cycle that also drops a push, in which case the flag stays 1.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave `fill_count` unchanged, and both operations take effect. A push and a pop together on an empty queue accept only the push.
- R11: When a host pop without `dma_pop_done` empties the queue, `drain_flag` stays 1 until one of the clears in R5 or R6 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Received word offered by the shift engine |
| push_data | input | WIDTH | Received word |
| pop_rd | input | 1 | Read strobe of the pop register |
| dma_pop_done | input | 1 | DMA reports that its pop register read has completed |
| clr_drain | input | 1 | Write of 1 to the drain flag bit |
| clr_ovf | input | 1 | Write of 1 to the overflow flag bit |
| pop_data | output | WIDTH | Oldest stored word (pop register read data) |
| fill_count | output | $clog2(DEPTH)+1 | Number of stored words |
| drain_flag | output | 1 | Drain request status |
| overflow_flag | output | 1 | Sticky dropped-push status |

## Verification
The hardest situations to reach are collisions where a clear arrives in the same cycle as an event that opposes it. Examples are a drain clear while a push lands in an empty queue, an overflow clear while a push is being dropped, and DMA completion on the very pop that removes the last word. The bench reaches each of these by driving single cycles in which it sets every strobe by hand. Before each such cycle it first brings the queue to an exact fill level: empty, one word, or full. A scoreboard queue of expected words checks the read data at each accepted pop, including after a dropped push and across pointer wraparound.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Encoding of the accepted operations in one cycle: {push, pop}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } rxq_op_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;

  // Entry storage: no reset on data, one write enable per entry
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic ent_we;
    assign ent_we = wr_en && (wr_ptr_q == AW'(gi));
    always_ff @(posedge clk) begin
      if (ent_we) begin
        mem[gi] <= wr_data;
      end
    end
  end

  // Pointer next state, wrapping at any depth
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) begin
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + AW'(1);
    end
    if (rd_en) begin
      rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= wr_ptr_d;
      if (rd_en) rd_ptr_q <= rd_ptr_d;
    end
  end

  assign rd_data = mem[rd_ptr_q];

endmodule

// File: rtl/rxq_occupancy.sv
module rxq_occupancy
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          push_drop,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] count_d
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rxq_op_e op;
  logic    full, empty;

  always_comb begin
    full      = (count_q == FULL_CNT);
    empty     = (count_q == '0);
    push_ok   = push_req && !full;
    push_drop = push_req && full;
    pop_ok    = pop_req && !empty;
    op        = rxq_op_e'({push_ok, pop_ok});
    unique case (op)
      OP_PUSH: count_d = count_q + CW'(1);
      OP_POP:  count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (op != OP_IDLE) begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_d,
  input  logic          dma_done,
  input  logic          clr_drain,
  input  logic          push_drop,
  input  logic          clr_ovf,
  output logic          drain_q,
  output logic          ovf_q
);

  logic drain_d, ovf_d;
  logic ends_empty;

  always_comb begin
    ends_empty = (count_d == '0);
    // Set wins: any word left after this cycle keeps the request up
    if (!ends_empty) begin
      drain_d = 1'b1;
    end else if (clr_drain || dma_done) begin
      drain_d = 1'b0;
    end else begin
      drain_d = drain_q;
    end

    if (push_drop) begin
      ovf_d = 1'b1;
    end else if (clr_ovf) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      drain_q <= drain_d;
      ovf_q   <= ovf_d;
    end
  end

endmodule

// File: rtl/rxq_drain_fifo.sv
module rxq_drain_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_rd,
  input  logic             dma_pop_done,
  input  logic             clr_drain,
  input  logic             clr_ovf,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    fill_count,
  output logic             drain_flag,
  output logic             overflow_flag
);

  logic          push_ok, pop_ok, push_drop;
  logic [CW-1:0] count_q, count_d;

  rxq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_valid),
    .pop_req  (pop_rd),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .push_drop(push_drop),
    .count_q  (count_q),
    .count_d  (count_d)
  );

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (push_ok),
    .wr_data(push_data),
    .rd_en  (pop_ok),
    .rd_data(pop_data)
  );

  rxq_status #(.CW(CW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_d  (count_d),
    .dma_done (dma_pop_done),
    .clr_drain(clr_drain),
    .push_drop(push_drop),
    .clr_ovf  (clr_ovf),
    .drain_q  (drain_flag),
    .ovf_q    (overflow_flag)
  );

  assign fill_count = count_q;

endmodule

// File: rtl/rxq_drain_fifo_chk.sv
module rxq_drain_fifo_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          pop_rd,
  input logic          dma_pop_done,
  input logic          clr_drain,
  input logic          clr_ovf,
  input logic [CW-1:0] fill_count,
  input logic          drain_flag,
  input logic          overflow_flag
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (fill_count == '0 && !drain_flag && !overflow_flag);
    end
  end

  a_r2_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rd && !push_valid && fill_count != '0 |=> fill_count == $past(fill_count) - CW'(1));

  a_r3_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rd && !push_valid && fill_count == '0 |=> fill_count == '0);

  a_r4_flag_when_stored: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count != '0 |-> drain_flag);

  a_r5_dma_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pop_done && !push_valid &&
    (fill_count == '0 || (fill_count == CW'(1) && pop_rd)) |=> !drain_flag);

  a_r6_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_drain && !push_valid && fill_count == '0 |=> !drain_flag);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_drain && push_valid && fill_count != FULL |=> drain_flag);

  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !pop_rd && fill_count == FULL |=> overflow_flag && fill_count == FULL);

  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf && !(push_valid && fill_count == FULL) |=> !overflow_flag);

  a_r10_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && pop_rd && fill_count != '0 && fill_count != FULL |=> $stable(fill_count));

  a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    drain_flag && !clr_drain && !dma_pop_done |=> drain_flag);

endmodule

bind rxq_drain_fifo rxq_drain_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rxq_drain_fifo_tb_top.sv
module rxq_drain_fifo_tb_top;

  localparam int DEPTH = 4;
  localparam int WIDTH = 32;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic             clk;
  logic             rst_n;
  logic             push_valid, pop_rd, dma_pop_done, clr_drain, clr_ovf;
  logic [WIDTH-1:0] push_data;
  logic [WIDTH-1:0] pop_data;
  logic [CW-1:0]    fill_count;
  logic             drain_flag, overflow_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [WIDTH-1:0] sb[$];
  int               m_cnt;
  bit               m_drain, m_ovf;

  rxq_drain_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_rd(pop_rd), .dma_pop_done(dma_pop_done), .clr_drain(clr_drain),
    .clr_ovf(clr_ovf), .pop_data(pop_data), .fill_count(fill_count),
    .drain_flag(drain_flag), .overflow_flag(overflow_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares the head word with the scoreboard at an accepted pop
  task automatic monitor_pop(input string req);
    logic [WIDTH-1:0] exp;
    exp = sb.pop_front();
    chk(req, "pop_data", 64'(pop_data), 64'(exp));
  endtask

  // Driver: one cycle of stimulus, called just after a falling edge
  task automatic step(input bit pu, input logic [WIDTH-1:0] d, input bit po,
                      input bit dm, input bit cd, input bit co, input string req);
    bit acc, pok;
    push_valid = pu; push_data = d; pop_rd = po;
    dma_pop_done = dm; clr_drain = cd; clr_ovf = co;
    #1;
    acc = pu && (m_cnt < DEPTH);
    pok = po && (m_cnt > 0);
    if (pok) monitor_pop(req);
    if (acc) sb.push_back(d);
    m_cnt = m_cnt + int'(acc) - int'(pok);
    if (m_cnt != 0) m_drain = 1'b1;
    else if (cd || dm) m_drain = 1'b0;
    if (pu && !acc) m_ovf = 1'b1;
    else if (co) m_ovf = 1'b0;
    @(posedge clk);
    @(negedge clk);
    push_valid = 0; pop_rd = 0; dma_pop_done = 0; clr_drain = 0; clr_ovf = 0;
    chk(req, "fill_count", 64'(fill_count), 64'(m_cnt));
    chk(req, "drain_flag", 64'(drain_flag), 64'(m_drain));
    chk(req, "overflow_flag", 64'(overflow_flag), 64'(m_ovf));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; push_valid = 0; push_data = '0; pop_rd = 0;
    dma_pop_done = 0; clr_drain = 0; clr_ovf = 0;
    m_cnt = 0; m_drain = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "fill_count", 64'(fill_count), 64'd0);
    chk("R1", "drain_flag", 64'(drain_flag), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "overflow_flag", 64'(overflow_flag), 64'd0);
    chk("R1", "fill_count", 64'(fill_count), 64'd0);

    // R2 / R4: ordered storage, flag raised
    step(1, 32'hA000_0001, 0, 0, 0, 0, "R4");
    step(1, 32'hA000_0002, 0, 0, 0, 0, "R2");
    step(1, 32'hA000_0003, 0, 0, 0, 0, "R2");
    step(0, '0, 1, 0, 0, 0, "R2");
    step(0, '0, 1, 0, 0, 0, "R2");
    // R11: host pop empties the queue, flag remains
    step(0, '0, 1, 0, 0, 0, "R11");
    step(0, '0, 0, 0, 0, 0, "R11");
    // R6: software clear on empty
    step(0, '0, 0, 0, 1, 0, "R6");
    // R3: pops on empty are ignored
    step(0, '0, 1, 0, 0, 0, "R3");
    step(0, '0, 1, 0, 0, 0, "R3");
    // R7: clear together with a push into an empty queue
    step(1, 32'hB000_0001, 0, 0, 1, 0, "R7");
    // R7: clear while words remain
    step(0, '0, 0, 0, 1, 0, "R7");
    // R5: DMA completion on a non-empty result keeps the flag
    step(1, 32'hB000_0002, 1, 1, 0, 0, "R5");
    // R5: DMA pop of the last word clears the flag
    step(0, '0, 1, 1, 0, 0, "R5");
    // R5: DMA completion indicated after a host pop emptied the queue
    step(1, 32'hB000_0003, 0, 0, 0, 0, "R5");
    step(0, '0, 1, 0, 0, 0, "R11");
    step(0, '0, 0, 1, 0, 0, "R5");

    // R8: fill, then a dropped push
    for (int i = 0; i < DEPTH; i++) step(1, 32'hC000_0000 + 32'(i), 0, 0, 0, 0, "R8");
    step(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R8");
    // R9: clear collides with another drop, flag stays
    step(1, 32'hDEAD_BEF0, 0, 0, 0, 1, "R9");
    // R9: plain clear
    step(0, '0, 0, 0, 0, 1, "R9");
    // R8: dropped words never appear in the read data
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1, 0, 0, 0, "R8");
    step(0, '0, 0, 0, 1, 0, "R6");

    // R10: push and pop together on an empty queue, only the push counts
    step(1, 32'hE000_0001, 1, 0, 0, 0, "R10");
    // R10: push and pop together in the middle range
    step(1, 32'hE000_0002, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 10; i++) step(1, 32'hF000_0000 + 32'(i), 1, 0, 0, 0, "R10");

    // R2: wraparound with a mix of fill levels
    for (int i = 0; i < 24; i++)
      step((i % 3) != 2, 32'h1234_0000 + 32'(i), (i % 2) == 1, 0, 0, 0, "R2");
    while (m_cnt > 0) step(0, '0, 1, (m_cnt == 1), 0, 0, "R5");

    finish_run();
  end

endmodule